// File: doc/BRIEF.md
# Three-Vector Multiplier Self-Test Sequencer

This block runs a short built-in check of a separate 32x32 array multiplier. It drives three fixed operand pairs onto the multiplier on three back-to-back cycles. It compares the 64-bit product that comes back against a known-good value in the same cycle that each pair is presented. The first pair is all zeros, which exposes product bits stuck at one. The second pair is an all-ones word times an alternating word. The third pair is the same two words with their sides exchanged. Together these exercise most of the partial-product array.

A run starts by itself on the first cycle after reset is released. It can be started again at any later time with a one-cycle start pulse while the block is idle. When the three cycles are over, the block raises done and reports a sticky fail flag. It also reports a two-bit code naming the first vector whose product was wrong. The multiplier under test sits outside this block and must be combinational from operands to product.

Top module: `mul_selftest`

## Requirements
- R1: While reset is high, and on the first edge after it, busy, done, fail, fail_idx, op_a and op_b are all zero.
- R2: On the first clock edge after reset falls, a run launches without any start pulse, so busy is high in the cycle that follows.
- R3: The three cycles of a run present, in order, (op_a, op_b) = (0, 0), then (all ones, alternating word), then (alternating word, all ones). The alternating word has bit i set exactly when i is odd (0xAAAAAAAA for 32 bits).
- R4: Each product is compared at the end of the cycle in which its pair is on the operands. For vector 0 the expected value is 0. For vectors 1 and 2 it is all-ones times the alternating word as a 64-bit number (0xAAAAAAA955555556 for 32 bits).
- R5: busy is high for exactly three cycles per run. done rises in the cycle after busy falls and stays high until the next launch. busy and done are never high together.
- R6: On a mismatch, fail goes high and fail_idx takes the vector number (0, 1 or 2) of the first failing vector. Later mismatches do not change fail_idx, and later matches do not clear fail. fail_idx is 0 when fail is low.
- R7: A start pulse while busy is high is ignored, including a pulse in the last vector cycle. No new run begins, and done rises as usual afterwards.
- R8: A start pulse while idle launches a new run. At launch, done, fail and fail_idx clear.
- R9: While busy is low, op_a and op_b are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new run when idle |
| op_a | output | 32 | Registered first operand to the multiplier |
| op_b | output | 32 | Registered second operand to the multiplier |
| prod | input | 64 | Product returned by the multiplier |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished |
| fail | output | 1 | The last run saw at least one wrong product |
| fail_idx | output | 2 | Vector number of the first wrong product |

## Verification
Two pairs of events can land in the same cycle. The first pair is a start request and the final comparison of a run. The bench raises start in the third vector cycle and then checks at the ports that busy falls, done rises and busy stays low in the following cycle. The second pair is a new mismatch and an already set fail flag. The bench model corrupts the product of two or all three vectors at once. The scoreboard then expects fail_idx to name the earliest faulted vector.

// File: rtl/mst_pkg.sv
package mst_pkg;
  localparam int NVEC = 3;
  localparam int IW   = 2;
  localparam logic [IW-1:0] LAST_VEC = IW'(NVEC - 1);
endpackage

// File: rtl/mst_opgen.sv
module mst_opgen
  import mst_pkg::*;
#(
  parameter int W = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vload,
  input  logic          vclr,
  input  logic [IW-1:0] vsel,
  output logic [W-1:0]  op_a,
  output logic [W-1:0]  op_b
);
  localparam logic [W-1:0] ONES = '1;
  logic [W-1:0] alt;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_alt
      assign alt[gi] = (gi % 2 == 1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || vclr) begin
      op_a <= '0;
      op_b <= '0;
    end else if (vload) begin
      case (vsel)
        2'd1:    begin op_a <= ONES; op_b <= alt;  end
        2'd2:    begin op_a <= alt;  op_b <= ONES; end
        default: begin op_a <= '0;   op_b <= '0;   end
      endcase
    end
  end
endmodule

// File: rtl/mst_cmp.sv
module mst_cmp
  import mst_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            valid,
  input  logic [IW-1:0]   vidx,
  input  logic [2*W-1:0]  prod,
  output logic            mismatch
);
  function automatic logic [2*W-1:0] ref_prod();
    logic [2*W-1:0] a;
    logic [2*W-1:0] b;
    a = '0;
    b = '0;
    for (int i = 0; i < W; i++) begin
      a[i] = 1'b1;
      b[i] = (i % 2 == 1);
    end
    return a * b;
  endfunction

  localparam logic [2*W-1:0] EXP_ZERO = '0;
  localparam logic [2*W-1:0] EXP_MIX  = ref_prod();

  logic [2*W-1:0] exp_val;

  always_comb begin
    case (vidx)
      2'd0:    exp_val = EXP_ZERO;
      default: exp_val = EXP_MIX;
    endcase
    mismatch = valid && (prod != exp_val);
  end
endmodule

// File: rtl/mst_seq.sv
module mst_seq
  import mst_pkg::*;
#(
  parameter bit RUN_AT_RESET = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          mismatch,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [IW-1:0] fail_idx,
  output logic [IW-1:0] vidx,
  output logic [IW-1:0] vsel,
  output logic          vload,
  output logic          vclr
);
  logic boot_pend;
  logic launch;
  logic at_last;

  assign launch  = (start || boot_pend) && !busy;
  assign at_last = (vidx == LAST_VEC);

  always_comb begin
    vsel  = launch ? '0 : IW'(vidx + 1'b1);
    vload = launch || (busy && !at_last);
    vclr  = busy && at_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_idx  <= '0;
      vidx      <= '0;
      boot_pend <= RUN_AT_RESET;
    end else if (launch) begin
      busy      <= 1'b1;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_idx  <= '0;
      vidx      <= '0;
      boot_pend <= 1'b0;
    end else if (busy) begin
      if (mismatch && !fail) begin
        fail     <= 1'b1;
        fail_idx <= vidx;
      end
      if (at_last) begin
        busy <= 1'b0;
        done <= 1'b1;
        vidx <= '0;
      end else begin
        vidx <= IW'(vidx + 1'b1);
      end
    end
  end
endmodule

// File: rtl/mul_selftest.sv
module mul_selftest #(
  parameter int W            = 32,
  parameter bit RUN_AT_RESET = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  output logic [W-1:0]   op_a,
  output logic [W-1:0]   op_b,
  input  logic [2*W-1:0] prod,
  output logic           busy,
  output logic           done,
  output logic           fail,
  output logic [1:0]     fail_idx
);
  logic       mismatch;
  logic [1:0] vidx;
  logic [1:0] vsel;
  logic       vload;
  logic       vclr;

  mst_seq #(.RUN_AT_RESET(RUN_AT_RESET)) u_seq (
    .clk(clk), .rst(rst), .start(start), .mismatch(mismatch),
    .busy(busy), .done(done), .fail(fail), .fail_idx(fail_idx),
    .vidx(vidx), .vsel(vsel), .vload(vload), .vclr(vclr)
  );

  mst_opgen #(.W(W)) u_opgen (
    .clk(clk), .rst(rst), .vload(vload), .vclr(vclr), .vsel(vsel),
    .op_a(op_a), .op_b(op_b)
  );

  mst_cmp #(.W(W)) u_cmp (
    .valid(busy), .vidx(vidx), .prod(prod), .mismatch(mismatch)
  );
endmodule

// File: rtl/mst_sva.sv
module mst_sva #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         busy,
  input logic         done,
  input logic         fail,
  input logic [1:0]   fail_idx,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b
);
  logic [2:0] run_len;
  always_ff @(posedge clk) begin
    if (rst || !busy) run_len <= '0;
    else if (run_len != 3'd7) run_len <= run_len + 3'd1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!busy && !done && !fail && fail_idx == 2'd0)); // R1
  AST_RUN_NOT_LONG: assert property (@(posedge clk) disable iff (rst)
    run_len <= 3'd3); // R7
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R5
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)); // R5
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fail && busy) |=> (fail && $stable(fail_idx))); // R6
  AST_IDX_ZERO_OK: assert property (@(posedge clk) disable iff (rst)
    !fail |-> fail_idx == 2'd0); // R6
  AST_IDLE_OPS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (op_a == '0 && op_b == '0)); // R9
endmodule

bind mul_selftest mst_sva #(.W(W)) u_sva (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .fail(fail),
  .fail_idx(fail_idx), .op_a(op_a), .op_b(op_b)
);

// File: tb/mul_selftest_tb.sv
module mul_selftest_tb;
  localparam int W = 32;
  localparam logic [W-1:0]   ONES = 32'hFFFF_FFFF;
  localparam logic [W-1:0]   ALT  = 32'hAAAA_AAAA;
  localparam logic [2*W-1:0] MIX  = 64'hAAAA_AAA9_5555_5556;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] op_a, op_b;
  logic [2*W-1:0] prod;
  logic busy, done, fail;
  logic [1:0] fail_idx;
  logic [2*W-1:0] m0 = '0, m1 = '0, m2 = '0;

  int checks = 0;
  int errors = 0;
  logic [2:0] expq[$];
  logic done_q = 1'b0;

  always #2.5 clk = ~clk;

  // Behavioural multiplier with per-vector fault masks
  always_comb begin
    prod = {32'd0, op_a} * {32'd0, op_b};
    if (op_a == '0 && op_b == '0) prod = prod ^ m0;
    else if (op_a == ONES) prod = prod ^ m1;
    else if (op_b == ONES) prod = prod ^ m2;
  end

  mul_selftest #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .prod(prod), .busy(busy), .done(done), .fail(fail), .fail_idx(fail_idx)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Scoreboard monitor: compares outcome when done rises
  always @(negedge clk) begin
    if (!rst && done && !done_q) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R6 unexpected completion", {61'd0, fail, fail_idx}, 64'd0);
      end else begin
        logic [2:0] e;
        e = expq.pop_front();
        chk({fail, fail_idx} == e, "R6 outcome", {61'd0, fail, fail_idx},
            {61'd0, e});
      end
    end
    done_q <= done;
  end

  // Checks the three vector cycles; the launch edge has just passed
  task automatic watch_run(input bit late_start);
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R5 busy in cycle 1", {62'd0, busy, done}, 64'd2);
    chk(op_a == '0 && op_b == '0, "R3 vector 0", {op_a, op_b}, 64'd0);
    @(negedge clk);
    chk(op_a == ONES && op_b == ALT, "R3 vector 1", {op_a, op_b}, {ONES, ALT});
    chk(prod == (MIX ^ m1), "R4 product 1", prod, MIX ^ m1);
    @(negedge clk);
    chk(op_a == ALT && op_b == ONES, "R3 vector 2", {op_a, op_b}, {ALT, ONES});
    chk(busy, "R5 busy in cycle 3", {63'd0, busy}, 64'd1);
    if (late_start) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!busy && done, "R5 done after three", {62'd0, busy, done}, 64'd1);
    chk(op_a == '0 && op_b == '0, "R9 idle operands", {op_a, op_b}, 64'd0);
    @(negedge clk);
    chk(!busy && done, "R7 start in busy ignored", {62'd0, busy, done}, 64'd1);
  endtask

  task automatic run_case(input logic [63:0] f0, input logic [63:0] f1,
                          input logic [63:0] f2, input logic [2:0] e,
                          input bit late_start);
    m0 = f0; m1 = f1; m2 = f2;
    expq.push_back(e);
    @(negedge clk);
    start = 1'b1;
    watch_run(late_start);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && fail_idx == 0, "R1 reset state",
        {60'd0, busy, done, fail, fail_idx[0]}, 64'd0);
    chk(op_a == '0 && op_b == '0, "R1 reset operands", {op_a, op_b}, 64'd0);
    // R2: boot run without start
    expq.push_back(3'b000);
    rst = 1'b0;
    @(posedge clk);
    watch_run(1'b0);
    chk(expq.size() == 0, "R2 boot run completed", 64'(expq.size()), 64'd0);
    repeat (2) @(negedge clk);
    chk(done && !busy, "R5 done held while idle", {62'd0, busy, done}, 64'd1);
    // R4 / R6: fault patterns
    run_case(64'd1, 0, 0, 3'b100, 1'b0);              // R4 vector 0 stuck bit
    run_case(0, 64'h8000_0000_0000_0000, 0, 3'b101, 1'b0);
    run_case(0, 0, 64'h10, 3'b110, 1'b0);
    run_case(0, 64'h2, 64'h4, 3'b101, 1'b0);          // R6 first failure kept
    run_case(64'h1, 64'h1, 64'h1, 3'b100, 1'b0);      // R6 all three wrong
    // R8: clean restart clears the flags; R7: start during last cycle
    run_case(0, 0, 0, 3'b000, 1'b1);
    chk(!fail && fail_idx == 0, "R8 flags cleared",
        {62'd0, fail, fail_idx[0]}, 64'd0);
    chk(expq.size() == 0, "R7 no extra run queued", 64'(expq.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule